// File: doc/BRIEF.md
# Five-level leg PWM and gate decoder

This block drives the three legs of a five-level drive built from two cascaded three-level inverters, one feeding each end of an open-winding motor. Each phase receives, once per sampling period, a switching time and a two-bit carrier-band code. A shared period counter runs from 0 to TS-1. Inside one period, each phase toggles only between the two adjacent voltage levels bounding its band. A comparison of the counter with the phase's switching time selects the upper or the lower level of that band. The chosen level is then decoded into the eight gate signals of that phase, spread over both three-level inverters.

Switching times and band codes are double-buffered, so a new set takes effect only at the period boundary. Each complementary switch pair passes through a dead time of DEAD clocks whenever it moves from one of its switches to the other. An enable input switches every gate off while low. When enable rises again, the counter starts a fresh period at 0. The block is intended to sit behind a modulator that computes the switching times and bands once per sample.

Top module: `fivelvl_leg_pwm`

## Requirements
- R1: Count the enabled clock edges as k = 0, 1, 2, ..., where edge 0 is the first edge at which enable is high after it was low. The gates seen just after edge k+1 correspond to the counter value k mod TS. Each period therefore lasts exactly TS clocks, and the count restarts from 0 whenever enable rises. The internal counter never reaches TS.
- R2: The band code selects a pair of levels. Code 11 selects +Vdc/2 and +Vdc/4. Code 10 selects +Vdc/4 and 0. Code 01 selects 0 and -Vdc/4. Code 00 selects -Vdc/4 and -Vdc/2.
- R3: For a phase with switching time T, the upper level of its band applies while the count is below T and the lower level applies from then on. T = 0 gives the lower level for the whole period. T = TS gives the upper level for the whole period.
- R4: Each phase's gate byte has bit 7 down to bit 0 as upper/lower switch of inverter A stage 1, upper/lower of inverter A stage 2, then the same for inverter B. The byte values are: +Vdc/2 = A5h, +Vdc/4 = 65h, 0 = 55h, -Vdc/4 = 56h, -Vdc/2 = 5Ah. These follow from the rule that inverter B sits at 0 for the positive levels and inverter A sits at 0 for the negative levels.
- R5: The switching times and band codes are captured only at the edge where the counter ends a period, and continuously while the block is disabled. A change at any other time has no effect on the gates.
- R6: The gate bit pairs (7,6), (5,4), (3,2) and (1,0) are complementary pairs. No pair ever has both bits high. When a pair moves from one switch to the other, both of its bits are low for exactly DEAD clocks before the new switch turns on. A pair that goes from off to on does so with no gap.
- R7: Every gate bit is low during reset. Every gate bit is low from the second clock edge onward while enable is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off, rising starts a new period |
| tg | input | NPH x CW | Per-phase switching time, 0 to TS, CW = clog2(TS+1) |
| band | input | NPH x 2 | Per-phase carrier-band code (11 top band ... 00 bottom band) |
| gate | output | NPH x 8 | Per-phase gate byte, bit 7 first in the order of R4 |

## Verification
The bench builds the block with TS = 16 and DEAD = 3. With these values, a full period is short enough to compare every count of several consecutive periods. The dead window still spans several counts, so an early or late release of a pair shows up. Switching times of 0 and of TS are reachable, and each is used for all three phases at once. In every period the bench also drives junk values midway, which tests the double buffering. A disable and re-enable sequence checks the forced-off state and the restart of the count from 0.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic [2:0] {
    LV_NEG2 = 3'd0,
    LV_NEG1 = 3'd1,
    LV_ZERO = 3'd2,
    LV_POS1 = 3'd3,
    LV_POS2 = 3'd4
  } level_e;

  // band code plus compare bit gives the level: code 00 spans NEG2..NEG1, 11 spans POS1..POS2
  function automatic level_e band_level(input logic [1:0] code, input logic upper);
    return level_e'({1'b0, code} + {2'b00, upper});
  endfunction

  // bit 7..0 = A1 hi, A1 lo, A2 hi, A2 lo, B1 hi, B1 lo, B2 hi, B2 lo
  function automatic logic [7:0] level_gates(input level_e lv);
    logic [7:0] g;
    case (lv)
      LV_POS2: g = 8'b1010_0101;
      LV_POS1: g = 8'b0110_0101;
      LV_ZERO: g = 8'b0101_0101;
      LV_NEG1: g = 8'b0101_0110;
      default: g = 8'b0101_1010;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/fl_period_ctr.sv
module fl_period_ctr #(
  parameter int TS = 1000,
  parameter int CW = $clog2(TS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          load
);

  logic last;
  assign last = (cnt == CW'(TS - 1));
  assign load = !run || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= en;
      if (!en || !run) cnt <= '0;
      else if (last)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fl_pair_dt.sv
module fl_pair_dt #(
  parameter int DEAD = 8,
  localparam int DW = $clog2(DEAD + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] want,
  output logic [1:0] out
);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      out  <= 2'b00;
      dcnt <= '0;
    end else if (want == 2'b00) begin
      out  <= 2'b00;
      dcnt <= '0;
    end else if (dcnt != '0) begin
      dcnt <= dcnt - 1'b1;
    end else if (out == want) begin
      out <= out;
    end else if (out == 2'b00) begin
      out <= want;
    end else begin
      out  <= 2'b00;
      dcnt <= DW'(DEAD - 1);
    end
  end

endmodule

// File: rtl/fl_phase.sv
module fl_phase
  import fl_pkg::*;
#(
  parameter int CW   = 10,
  parameter int DEAD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] tg_in,
  input  logic [1:0]    band_in,
  output logic [7:0]    gate
);

  logic [CW-1:0] tg_q;
  logic [1:0]    band_q;
  logic          upper;
  logic [7:0]    want;

  always_ff @(posedge clk) begin
    if (rst) begin
      tg_q   <= '0;
      band_q <= 2'b00;
    end else if (load) begin
      tg_q   <= tg_in;
      band_q <= band_in;
    end
  end

  assign upper = (cnt < tg_q);
  assign want  = run ? level_gates(band_level(band_q, upper)) : 8'h00;

  for (genvar p = 0; p < 4; p++) begin : g_pair
    fl_pair_dt #(.DEAD(DEAD)) u_pair (
      .clk  (clk),
      .rst  (rst),
      .want (want[2*p+1:2*p]),
      .out  (gate[2*p+1:2*p])
    );
  end

endmodule

// File: rtl/fivelvl_leg_pwm.sv
module fivelvl_leg_pwm #(
  parameter int NPH  = 3,
  parameter int TS   = 1000,
  parameter int DEAD = 8,
  localparam int CW  = $clog2(TS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [NPH-1:0][CW-1:0]  tg,
  input  logic [NPH-1:0][1:0]     band,
  output logic [NPH-1:0][7:0]     gate
);

  logic [CW-1:0] cnt;
  logic          run;
  logic          load;

  fl_period_ctr #(.TS(TS), .CW(CW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .cnt  (cnt),
    .run  (run),
    .load (load)
  );

  for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
    fl_phase #(.CW(CW), .DEAD(DEAD)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .load    (load),
      .cnt     (cnt),
      .tg_in   (tg[ph]),
      .band_in (band[ph]),
      .gate    (gate[ph])
    );
  end

endmodule

// File: rtl/fl_chk.sv
module fl_chk #(
  parameter int NPH = 3,
  parameter int TS  = 1000,
  parameter int CW  = $clog2(TS + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic [NPH-1:0][7:0]    gate,
  input logic [CW-1:0]          cnt,
  input logic                   run
);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt < CW'(TS)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst) (run && en && cnt == CW'(TS - 1)) |=> cnt == '0); // R1
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst) $rose(run) |-> cnt == '0); // R1
  AST_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst) (!en && $past(!en)) |=> gate == '0); // R7

  for (genvar ph = 0; ph < NPH; ph++) begin : g_ph
    for (genvar pr = 0; pr < 4; pr++) begin : g_pr
      AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst) !(gate[ph][2*pr+1] && gate[ph][2*pr])); // R6
      AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst) ($past(gate[ph][2*pr+1:2*pr]) != 2'b00 && gate[ph][2*pr+1:2*pr] != 2'b00) |-> gate[ph][2*pr+1:2*pr] == $past(gate[ph][2*pr+1:2*pr])); // R6
    end
  end

endmodule

bind fivelvl_leg_pwm fl_chk #(.NPH(NPH), .TS(TS), .CW(CW)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .en   (en),
  .gate (gate),
  .cnt  (cnt),
  .run  (run)
);

// File: tb/fivelvl_leg_pwm_tb.sv
`timescale 1ns/1ps
module fivelvl_leg_pwm_tb;

  localparam int NPH  = 3;
  localparam int TS   = 16;
  localparam int DEAD = 3;
  localparam int CW   = $clog2(TS + 1);
  localparam int NV   = 8;
  localparam int NPER = 4;

  // per vector: band {C,B,A}, times {C,B,A}
  localparam logic [5:0] VBAND [NV] = '{
    {2'b01, 2'b10, 2'b11}, {2'b10, 2'b11, 2'b00},
    {2'b11, 2'b00, 2'b01}, {2'b00, 2'b01, 2'b10},
    {2'b11, 2'b11, 2'b11}, {2'b00, 2'b00, 2'b00},
    {2'b01, 2'b00, 2'b10}, {2'b11, 2'b10, 2'b01}
  };
  localparam logic [14:0] VTG [NV] = '{
    {5'd8,  5'd8,  5'd8},  {5'd6,  5'd0,  5'd16},
    {5'd0,  5'd16, 5'd10}, {5'd16, 5'd6,  5'd0},
    {5'd16, 5'd16, 5'd16}, {5'd0,  5'd0,  5'd0},
    {5'd10, 5'd9,  5'd7},  {5'd7,  5'd10, 5'd6}
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   en  = 1'b0;
  logic [NPH-1:0][CW-1:0] tg  = '0;
  logic [NPH-1:0][1:0]    band = '0;
  logic [NPH-1:0][7:0]    gate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] hist [NPH][NPER*TS];

  always #2 clk = ~clk;

  fivelvl_leg_pwm #(.NPH(NPH), .TS(TS), .DEAD(DEAD)) u_dut (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .tg   (tg),
    .band (band),
    .gate (gate)
  );

  // R4 byte per level, level = band code + upper (R2, R3)
  function automatic logic [7:0] exp_byte(input logic [1:0] code, input bit up);
    int lv;
    lv = int'(code) + (up ? 1 : 0);
    case (lv)
      4: return 8'hA5;
      3: return 8'h65;
      2: return 8'h55;
      1: return 8'h56;
      default: return 8'h5A;
    endcase
  endfunction

  task automatic chk(input string tag, input int k, input int ph,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s count %0d phase %0d: actual %h expected %h", tag, k, ph, act, exp);
    end
  endtask

  task automatic apply_vec(input int v);
    for (int ph = 0; ph < NPH; ph++) begin
      tg[ph]   = VTG[v][5*ph +: 5];
      band[ph] = VBAND[v][2*ph +: 2];
    end
  endtask

  task automatic apply_junk();
    for (int ph = 0; ph < NPH; ph++) begin
      tg[ph]   = CW'(3);
      band[ph] = ~band[ph];
    end
  endtask

  task automatic check_count(input int k, input int first, input bit second_run);
    for (int ph = 0; ph < NPH; ph++) begin
      logic [7:0] exp;
      bit in_dead;
      in_dead = 1'b0;
      for (int pr = 0; pr < 4; pr++) begin
        logic [1:0] d;
        d = hist[ph][k][2*pr +: 2];
        exp[2*pr +: 2] = d;
        for (int j = 1; j <= DEAD; j++) begin
          if (k - j >= 0 && hist[ph][k-j][2*pr +: 2] != d) begin
            exp[2*pr +: 2] = 2'b00;
            in_dead = 1'b1;
          end
        end
      end
      if (in_dead)                    chk("R6", k, ph, gate[ph], exp);
      else if (second_run && k < TS)  chk("R1", k, ph, gate[ph], exp);
      else if (first + k / TS == 4 || first + k / TS == 5)
                                      chk("R3", k, ph, gate[ph], exp);
      else if (k % TS > 8)            chk("R5", k, ph, gate[ph], exp);
      else if (k % TS < 4)            chk("R4", k, ph, gate[ph], exp);
      else                            chk("R2", k, ph, gate[ph], exp);
    end
  endtask

  // one loop walks NPER vectors of the table, one per period
  task automatic run_seg(input int first, input bit second_run);
    for (int k = 0; k <= NPER * TS; k++) begin
      if (k < NPER * TS) begin
        int v;
        v = first + k / TS;
        if (k % TS == 0) apply_vec(v);
        for (int ph = 0; ph < NPH; ph++)
          hist[ph][k] = exp_byte(VBAND[v][2*ph +: 2], (k % TS) < int'(VTG[v][5*ph +: 5]));
        if (k % TS == 8) apply_junk();   // R5: mid-period change must be ignored
      end
      if (k == 0) en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (k >= 1) check_count(k - 1, first, second_run);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int ph = 0; ph < NPH; ph++) chk("R7", -1, ph, gate[ph], 8'h00);  // reset
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int ph = 0; ph < NPH; ph++) chk("R7", -1, ph, gate[ph], 8'h00);  // idle disabled
    run_seg(0, 1'b0);
    en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int ph = 0; ph < NPH; ph++) chk("R7", -1, ph, gate[ph], 8'h00);  // disable mid-run
    repeat (5) @(posedge clk);
    @(negedge clk);
    for (int ph = 0; ph < NPH; ph++) chk("R7", -1, ph, gate[ph], 8'h00);  // stays off
    run_seg(4, 1'b1);  // R1: restart from count 0
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule